// File: doc/BRIEF.md
# Prioritised Sixteen-Source Interrupt Controller

This block collects single-cycle event pulses from sixteen peripheral sources and turns them into one interrupt request line for a processor. Each source owns one bit in four 16-bit registers: enable, pending, mask and in-service. An event is latched only if its source is enabled. A latched event raises the request only if its mask bit is also set. The bit positions are fixed and carry priority, with bit 15 highest and bit 0 lowest:

- bits 0–3: general-purpose inputs 0–3
- bit 4: timer D
- bit 5: timer C
- bits 6–7: general-purpose inputs 4–5
- bit 8: timer B
- bits 9 and 11: serial transmit and receive errors
- bit 10: transmit buffer empty
- bit 12: receive buffer full
- bit 13: timer A
- bits 14–15: general-purpose inputs 6–7

Software reaches the registers over a synchronous address/data port. Writes take effect at the clock edge, and reads are combinational from the register outputs. The addresses are: 0 enable, 1 pending, 2 mask, 3 in-service, 4 vector. The vector register holds a four-bit vector base in bits 7:4 and the end-of-interrupt mode bit in bit 3.

The processor acknowledges with a one-cycle pulse on `ack_req`. A two-state handshake machine answers it. In ACK_IDLE it accepts the request, picks the winning source and updates the registers at that edge, then moves to ACK_REPLY (transition "accept"). ACK_REPLY presents `ack_vector` with `ack_valid` for exactly one cycle and always returns to ACK_IDLE (transition "finish"). In software end-of-interrupt mode, an acknowledge also marks the winning source as in service. That blocks lower-priority requests until software clears the in-service bit.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all five registers read as zero, and `irq` and `ack_valid` are low.
- R2: An event pulse on `src_evt[i]` sets pending bit i at that clock edge only if enable bit i was already set. An event for a disabled source is lost.
- R3: `irq` is a registered output. It goes high one cycle after some source is pending, masked in and not blocked by the in-service rule (R8). A pending source whose mask bit is zero never raises `irq`.
- R4: A write that clears enable bit i also clears pending bit i at the same edge, even if an event for source i arrives in that cycle.
- R5: A write to address 1 ANDs the written data into the pending register, so software can clear pending bits but never set them. An event arriving in the same cycle as the clearing write keeps its pending bit set.
- R6: With vector bit 3 at 0, an accepted acknowledge clears the winner's pending bit and leaves the in-service register unchanged.
- R7: With vector bit 3 at 1, an accepted acknowledge clears the winner's pending bit and sets its in-service bit. A write to address 3 ANDs the written data into the in-service register. No in-service bit is ever set except by an acknowledge in this mode.
- R8: While in-service bit j is set, sources below bit j neither raise `irq` nor win an acknowledge. Source j itself and sources above it still do.
- R9: An acknowledge services the eligible source with the highest bit position.
- R10: `ack_valid` is high for exactly the cycle after an accepted `ack_req`. In that cycle `ack_vector` equals {vector[7:4], winner number in 4 bits}.
- R11: An acknowledge with no eligible source returns {vector[7:4], 4'h0} and leaves every register unchanged.
- R12: An `ack_req` that arrives in the cycle in which `ack_valid` is high is ignored. It produces no vector and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 16 | Single-cycle event pulse per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 enable, 1 pending, 2 mask, 3 in-service, 4 vector) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| ack_req | input | 1 | Acknowledge request pulse from the processor |
| ack_valid | output | 1 | Vector byte valid, one cycle |
| ack_vector | output | 8 | Vector byte for the serviced source |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The embedded assertions watch four rules on every cycle:
- no pending bit appears for a source that was disabled;
- `irq` never rises without some pending, masked-in source behind it;
- no in-service bit appears without an accepted acknowledge in software mode;
- `ack_valid` never lasts two cycles.

Other behaviours depend on the order of events and can only be shown by the bench's scenarios:
- the exact choice of winner under in-service blocking;
- the equal-priority case;
- the AND semantics of pending and in-service writes racing with new events;
- the empty acknowledge that leaves state untouched.

These scenarios are run both as directed sequences and under long random traffic compared against a reference model.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Register addresses on the bus port
    localparam logic [2:0] ADR_ENABLE = 3'd0;
    localparam logic [2:0] ADR_PEND   = 3'd1;
    localparam logic [2:0] ADR_MASK   = 3'd2;
    localparam logic [2:0] ADR_INSRV  = 3'd3;
    localparam logic [2:0] ADR_VECTOR = 3'd4;

    // Acknowledge handshake states
    typedef enum logic {
        ACK_IDLE  = 1'b0,
        ACK_REPLY = 1'b1
    } ack_state_t;

endpackage

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
    parameter int NSRC = 16,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] mask,
    input  logic [NSRC-1:0] insrv,
    output logic            any_elig,
    output logic [IDXW-1:0] win_idx
);

    // blocked_by_above[i] is set when some in-service bit above i is set
    logic [NSRC-1:0] blocked_by_above;
    logic [NSRC-1:0] elig;

    assign blocked_by_above[NSRC-1] = 1'b0;

    generate
        for (genvar g = 0; g < NSRC - 1; g++) begin : g_block
            assign blocked_by_above[g] = blocked_by_above[g+1] | insrv[g+1];
        end
    endgenerate

    assign elig     = pend & mask & ~blocked_by_above;
    assign any_elig = |elig;

    // Highest set bit wins; the lowest index is returned when none is set
    always_comb begin
        win_idx = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (elig[k]) begin
                win_idx = IDXW'(k);
            end
        end
    end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_evt,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [NSRC-1:0] wr_data,
    input  logic            take,
    input  logic [IDXW-1:0] take_idx,
    input  logic            sw_eoi,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] pend_q,
    output logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] insrv_q
);

    logic [NSRC-1:0] en_d, pend_d, mask_d, insrv_d;

    always_comb begin
        en_d    = en_q;
        mask_d  = mask_q;
        pend_d  = pend_q;
        insrv_d = insrv_q;

        if (wr_en && wr_addr == ADR_ENABLE) en_d = wr_data;
        if (wr_en && wr_addr == ADR_MASK)   mask_d = wr_data;

        // Pending: software can only clear, acknowledge clears the winner
        if (wr_en && wr_addr == ADR_PEND) pend_d = pend_d & wr_data;
        if (take) pend_d[take_idx] = 1'b0;
        // New events win over clears, but only for sources enabled now
        pend_d = pend_d | (src_evt & en_q);
        // Disabling a source drops its pending bit at once
        pend_d = pend_d & en_d;

        if (wr_en && wr_addr == ADR_INSRV) insrv_d = insrv_d & wr_data;
        if (take && sw_eoi) insrv_d[take_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            mask_q  <= '0;
            pend_q  <= '0;
            insrv_q <= '0;
        end else begin
            en_q    <= en_d;
            mask_q  <= mask_d;
            pend_q  <= pend_d;
            insrv_q <= insrv_d;
        end
    end

    // R2
    pend_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q)) & ~$past(en_q)) == '0);

    // R7
    insrv_from_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((insrv_q & ~$past(insrv_q)) != '0) |-> $past(take && sw_eoi));

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int IDXW  = $clog2(NSRC),
    parameter int VEC_W = 8,
    localparam int BASE_W = VEC_W - IDXW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_req,
    input  logic              any_elig,
    input  logic [IDXW-1:0]   win_idx,
    input  logic [BASE_W-1:0] vec_base,
    output logic              take,
    output logic              ack_valid,
    output logic [VEC_W-1:0]  ack_vector
);

    ack_state_t state_q, state_d;
    logic       accept;

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ACK_IDLE: begin
                if (ack_req) begin
                    accept  = 1'b1;
                    state_d = ACK_REPLY;
                end
            end
            ACK_REPLY: begin
                state_d = ACK_IDLE;
            end
            default: state_d = ACK_IDLE;
        endcase
    end

    // The registers change only when a real source is taken
    assign take = accept & any_elig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_vector <= '0;
        end else begin
            ack_valid <= accept;
            if (accept) begin
                ack_vector <= any_elig ? {vec_base, win_idx} : {vec_base, {IDXW{1'b0}}};
            end
        end
    end

    // R12
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int VEC_W = 8,
    localparam int IDXW   = $clog2(NSRC),
    localparam int BASE_W = VEC_W - IDXW,
    localparam int SW_BIT = IDXW - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_evt,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [NSRC-1:0]  bus_wdata,
    output logic [NSRC-1:0]  bus_rdata,
    input  logic             ack_req,
    output logic             ack_valid,
    output logic [VEC_W-1:0] ack_vector,
    output logic             irq
);

    logic [NSRC-1:0]  en_q, pend_q, mask_q, insrv_q;
    logic [VEC_W-1:0] vec_q;
    logic             any_elig, take;
    logic [IDXW-1:0]  win_idx;

    irq_src_bank #(.NSRC(NSRC), .IDXW(IDXW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (src_evt),
        .wr_en    (bus_wr),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .take     (take),
        .take_idx (win_idx),
        .sw_eoi   (vec_q[SW_BIT]),
        .en_q     (en_q),
        .pend_q   (pend_q),
        .mask_q   (mask_q),
        .insrv_q  (insrv_q)
    );

    irq_prio_select #(.NSRC(NSRC), .IDXW(IDXW)) u_sel (
        .pend     (pend_q),
        .mask     (mask_q),
        .insrv    (insrv_q),
        .any_elig (any_elig),
        .win_idx  (win_idx)
    );

    irq_ack_fsm #(.NSRC(NSRC), .IDXW(IDXW), .VEC_W(VEC_W)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_req    (ack_req),
        .any_elig   (any_elig),
        .win_idx    (win_idx),
        .vec_base   (vec_q[VEC_W-1 -: BASE_W]),
        .take       (take),
        .ack_valid  (ack_valid),
        .ack_vector (ack_vector)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '0;
        else if (bus_wr && bus_addr == ADR_VECTOR) vec_q <= bus_wdata[VEC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= any_elig;
    end

    always_comb begin
        unique case (bus_addr)
            ADR_ENABLE: bus_rdata = en_q;
            ADR_PEND:   bus_rdata = pend_q;
            ADR_MASK:   bus_rdata = mask_q;
            ADR_INSRV:  bus_rdata = insrv_q;
            ADR_VECTOR: bus_rdata = {{(NSRC-VEC_W){1'b0}}, vec_q};
            default:    bus_rdata = '0;
        endcase
    end

    // R3
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((pend_q & mask_q) != '0));

endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_evt = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ack_req = 1'b0;
    logic        ack_valid;
    logic [7:0]  ack_vector;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_req(ack_req), .ack_valid(ack_valid), .ack_vector(ack_vector), .irq(irq)
    );

    // Reference model state
    logic [15:0] m_en = '0, m_pend = '0, m_mask = '0, m_isr = '0;
    logic [7:0]  m_vec = '0, m_avec = '0;
    logic        m_irq = 0, m_av = 0, m_st = 0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] elig_of(input logic [15:0] p, input logic [15:0] mk, input logic [15:0] is);
        logic [15:0] above;
        above = '0;
        for (int k = 14; k >= 0; k--) above[k] = above[k+1] | is[k+1];
        return p & mk & ~above;
    endfunction

    function automatic logic [3:0] top_of(input logic [15:0] el);
        logic [3:0] w;
        w = '0;
        for (int k = 0; k < 16; k++) if (el[k]) w = 4'(k);
        return w;
    endfunction

    // One clock cycle: drive at negedge, model next state, check at next negedge
    task automatic step(input logic [15:0] evt, input logic wr, input logic [2:0] a,
                        input logic [15:0] d, input logic ak);
        logic [15:0] el, p, i, en_n, mk_n;
        logic [7:0]  v_n, avec_n;
        logic [3:0]  w;
        logic        any, tk, av_n;
        src_evt = evt; bus_wr = wr; bus_addr = a; bus_wdata = d; ack_req = ak;
        el  = elig_of(m_pend, m_mask, m_isr);
        any = |el;
        w   = top_of(el);
        tk  = !m_st && ak && any;
        en_n = (wr && a == 3'd0) ? d : m_en;
        mk_n = (wr && a == 3'd2) ? d : m_mask;
        v_n  = (wr && a == 3'd4) ? d[7:0] : m_vec;
        p = m_pend;
        if (wr && a == 3'd1) p = p & d;
        if (tk) p[w] = 1'b0;
        p = (p | (evt & m_en)) & en_n;
        i = m_isr;
        if (wr && a == 3'd3) i = i & d;
        if (tk && m_vec[3]) i[w] = 1'b1;
        av_n   = !m_st && ak;
        avec_n = any ? {m_vec[7:4], w} : {m_vec[7:4], 4'h0};
        @(posedge clk);
        #1;
        m_en = en_n; m_mask = mk_n; m_vec = v_n; m_pend = p; m_isr = i;
        m_irq = any; m_st = av_n; m_av = av_n;
        if (av_n) m_avec = avec_n;
        @(negedge clk);
        chk("R3 irq", {15'd0, irq}, {15'd0, m_irq});
        chk("R12 ack_valid", {15'd0, ack_valid}, {15'd0, m_av});
        if (m_av) chk("R10 ack_vector", {8'd0, ack_vector}, {8'd0, m_avec});
        case (a)
            3'd0: chk("R4 enable", bus_rdata, m_en);
            3'd1: chk("R2 pending", bus_rdata, m_pend);
            3'd2: chk("R3 mask", bus_rdata, m_mask);
            3'd3: chk("R7 in-service", bus_rdata, m_isr);
            3'd4: chk("R7 vector", bus_rdata, {8'd0, m_vec});
            default: chk("R1 unused address", bus_rdata, 16'd0);
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        step(16'd0, 1'b0, a, 16'd0, 1'b0);
        v = bus_rdata;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 ack_valid", {15'd0, ack_valid}, 16'd0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 register", v, 16'd0);
        end

        // R2 disabled event is lost
        step(16'h0008, 0, 3'd0, 0, 0);
        rd(3'd1, v); chk("R2 disabled", v, 16'h0000);
        step(16'h0000, 1, 3'd0, 16'hFFFF, 0);
        step(16'h0008, 0, 3'd0, 0, 0);
        rd(3'd1, v); chk("R2 enabled", v, 16'h0008);
        chk("R3 masked no irq", {15'd0, irq}, 16'd0);

        // R5 event beats clear, write cannot set
        step(16'h0008, 1, 3'd1, 16'h0000, 0);
        rd(3'd1, v); chk("R5 event wins", v, 16'h0008);
        step(16'h0000, 1, 3'd1, 16'hFFFF, 0);
        rd(3'd1, v); chk("R5 no set", v, 16'h0008);

        // R4 disabling drops pending
        step(16'h0000, 1, 3'd0, 16'hFFF7, 0);
        rd(3'd1, v); chk("R4 drop", v, 16'h0000);
        step(16'h0000, 1, 3'd0, 16'hFFFF, 0);

        // R3 / R9 / R6 in automatic mode
        step(16'h0011, 1, 3'd2, 16'hFFFF, 0);
        rd(3'd1, v);
        chk("R3 irq up", {15'd0, irq}, 16'd1);
        step(16'h0000, 0, 3'd1, 0, 1);
        chk("R9 highest", {8'd0, ack_vector}, 16'h0004);
        rd(3'd1, v); chk("R6 pend cleared", v, 16'h0001);
        rd(3'd3, v); chk("R6 no in-service", v, 16'h0000);

        // R7 software mode
        step(16'h0000, 1, 3'd1, 16'h0000, 0);
        step(16'h0000, 1, 3'd4, 16'h00A8, 0);
        step(16'h0100, 0, 3'd0, 0, 0);
        step(16'h0000, 0, 3'd1, 0, 1);
        chk("R10 vector", {8'd0, ack_vector}, 16'h00A8);
        rd(3'd3, v); chk("R7 in-service set", v, 16'h0100);

        // R8 lower priority blocked
        step(16'h0008, 0, 3'd0, 0, 0);
        rd(3'd1, v);
        chk("R8 blocked", {15'd0, irq}, 16'd0);
        // R11 empty acknowledge
        step(16'h0000, 0, 3'd1, 0, 1);
        chk("R11 vector", {8'd0, ack_vector}, 16'h00A0);
        rd(3'd1, v); chk("R11 pend kept", v, 16'h0008);
        rd(3'd3, v); chk("R11 isr kept", v, 16'h0100);
        // R8 equal priority passes
        step(16'h0100, 0, 3'd0, 0, 0);
        rd(3'd1, v);
        chk("R8 equal", {15'd0, irq}, 16'd1);
        step(16'h0000, 1, 3'd3, 16'hFEFF, 0);
        rd(3'd3, v); chk("R7 isr clear", v, 16'h0000);

        // R12 second request during reply ignored
        step(16'h0000, 0, 3'd1, 0, 1);
        chk("R12 first", {8'd0, ack_vector}, 16'h00A8);
        step(16'h0000, 0, 3'd1, 0, 1);
        chk("R12 ignored", {15'd0, ack_valid}, 16'd0);
        rd(3'd1, v); chk("R12 pend kept", v, 16'h0008);

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] e, d;
            logic [2:0]  a;
            logic        w;
            e = 16'($urandom) & 16'($urandom) & 16'($urandom);
            w = ($urandom % 4) == 0;
            a = 3'($urandom % 5);
            d = 16'($urandom);
            if (a == 3'd0 || a == 3'd2) d = d | 16'($urandom);
            if (a == 3'd3 || a == 3'd1) d = d | 16'($urandom) | 16'($urandom);
            step(e, w, a, d, ($urandom % 3) == 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule